// File: doc/BRIEF.md
# DMA Channel Priority Arbiter with Operation Register

This block chooses which of four DMA channels may transfer next, and holds the 16-bit operation register that sets up that choice. Each cycle the arbiter looks at the four request lines. It then drives a one-hot grant, a binary channel index and a valid flag. All three are combinational from the current requests and register state. A two-bit mode field selects the ordering. It can be one of three fixed orderings, or a rotating round-robin scheme that moves on once per accepted grant.

The operation register has the mode field, a master enable and two sticky error flags. The address-error flag and the non-maskable-interrupt flag are set by single-cycle event inputs. Software can clear a flag only by writing 0 to it, and only after a register read has returned 1 for that flag. While either flag is set, or while the enable is low, no grant is issued. A standby indication clears the register and the round-robin pointer in the same way as power-on reset.

Top module: `dma_prio_arb`

## Requirements
- R1: After power-on reset the register reads 0x0000 and no grant is issued, even with all requests active.
- R2: Bits 15..10 and 7..3 of the register always read 0, whatever was written to them.
- R3: With mode bits [9:8] = 00 the ordering is channel 0, then 1, then 2, then 3, the first one listed winning.
- R4: With mode 01 the ordering is channel 0, then 2, then 3, then 1.
- R5: With mode 10 the ordering is channel 2, then 0, then 1, then 3.
- R6: With mode 11 the arbiter uses round-robin, starting at channel 0 after reset. When grantAck is high with a valid grant, the channel after the granted one in numeric order, wrapping from 3 to 0, becomes the first in order.
- R7: No grant is issued while enable (bit 0) is 0, or while the address-error flag (bit 2) or the NMI flag (bit 1) is 1.
- R8: An event input sets its flag on the next clock edge. Writing 1 to a flag has no effect. Writing 0 to a flag that has not been read as 1 also leaves it set.
- R9: A read (regRdEn) that returns 1 for a flag arms that flag. A later write of 0 to it then clears it. If an event for the same flag arrives in the cycle of the clearing write, the flag stays set.
- R10: standbyClr clears the whole register to 0 and returns the round-robin order to start at channel 0.
- R11: grantOneHot has at most one bit set. That bit matches grantIdx and lies on an active request, and grantValid is high exactly when a bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| standbyClr | input | 1 | Synchronous clear from a standby state |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regRdEn | input | 1 | Register read strobe; arms flag clearing |
| regRdData | output | 16 | Current register value |
| addrErrEvt | input | 1 | Address-error event pulse |
| nmiEvt | input | 1 | NMI event pulse |
| reqIn | input | 4 | Channel transfer requests |
| grantAck | input | 1 | Granted transfer accepted; advances round-robin |
| grantValid | output | 1 | A grant is issued |
| grantIdx | output | 2 | Index of the granted channel |
| grantOneHot | output | 4 | One-hot grant |

## Verification
The assertions take two things for granted. First, event inputs are single-cycle pulses. Second, standbyClr and regWrEn are never used as ways to keep a flag set. The flag-hold property therefore excludes cycles that have a clearing write or a standby clear. The stimulus changes every input once per cycle, shortly after the rising edge. It raises each event for exactly one cycle and asserts grantAck only while a grant is visible. Under these conditions the round-robin step and the flag behaviour are fully determined at the ports.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int CH_NUM  = 4;
  localparam int IDX_W   = $clog2(CH_NUM);
  localparam int REG_W   = 16;
  localparam int MODE_LO = 8;
  localparam int AE_BIT  = 2;
  localparam int NMI_BIT = 1;
  localparam int EN_BIT  = 0;

  typedef enum logic [1:0] {
    MODE_LINEAR = 2'b00,
    MODE_ALT_A  = 2'b01,
    MODE_ALT_B  = 2'b10,
    MODE_ROTATE = 2'b11
  } arbMode_e;

  typedef struct packed {
    arbMode_e mode;
    logic     allow;
    logic     ptrReset;
  } arbCtrl_t;
endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             standbyClr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             regRdEn,
  input  logic             addrErrEvt,
  input  logic             nmiEvt,
  output logic [REG_W-1:0] regRdData,
  output arbCtrl_t         ctrlOut
);
  arbMode_e modeQ;
  logic enQ, aeQ, nmiQ, aeArmQ, nmiArmQ;
  logic aeClr, nmiClr;

  // A flag clears on a write of 0, and only once it has been armed by a read.
  assign aeClr  = regWrEn && !regWrData[AE_BIT]  && aeArmQ;
  assign nmiClr = regWrEn && !regWrData[NMI_BIT] && nmiArmQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_LINEAR; enQ <= 1'b0; aeQ <= 1'b0; nmiQ <= 1'b0;
      aeArmQ <= 1'b0; nmiArmQ <= 1'b0;
    end else if (standbyClr) begin
      modeQ <= MODE_LINEAR; enQ <= 1'b0; aeQ <= 1'b0; nmiQ <= 1'b0;
      aeArmQ <= 1'b0; nmiArmQ <= 1'b0;
    end else begin
      if (regWrEn) begin
        modeQ <= arbMode_e'(regWrData[MODE_LO +: 2]);
        enQ   <= regWrData[EN_BIT];
      end
      // An event takes precedence over a clearing write.
      if (addrErrEvt)  aeQ <= 1'b1;
      else if (aeClr)  aeQ <= 1'b0;
      if (nmiEvt)      nmiQ <= 1'b1;
      else if (nmiClr) nmiQ <= 1'b0;
      if (aeClr && !addrErrEvt)    aeArmQ <= 1'b0;
      else if (regRdEn && aeQ)     aeArmQ <= 1'b1;
      if (nmiClr && !nmiEvt)       nmiArmQ <= 1'b0;
      else if (regRdEn && nmiQ)    nmiArmQ <= 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    regRdData[MODE_LO +: 2] = modeQ;
    regRdData[AE_BIT]       = aeQ;
    regRdData[NMI_BIT]      = nmiQ;
    regRdData[EN_BIT]       = enQ;
  end

  assign ctrlOut.mode     = modeQ;
  assign ctrlOut.allow    = enQ && !aeQ && !nmiQ;
  assign ctrlOut.ptrReset = standbyClr;
endmodule

// File: rtl/dma_arb_path.sv
module dma_arb_path
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  arbCtrl_t          ctrlIn,
  input  logic [CH_NUM-1:0] reqIn,
  input  logic              grantAck,
  output logic              grantValid,
  output logic [IDX_W-1:0]  grantIdx,
  output logic [CH_NUM-1:0] grantOneHot
);
  logic [IDX_W-1:0] ptrQ;

  // Returns the channel that sits at a given rank (0 = highest) for a mode.
  function automatic logic [IDX_W-1:0] chanAt(arbMode_e m, logic [IDX_W-1:0] p,
                                              logic [IDX_W-1:0] rank);
    logic [IDX_W-1:0] c;
    case (m)
      MODE_ALT_A: case (rank)
                    2'd0: c = 2'd0; 2'd1: c = 2'd2; 2'd2: c = 2'd3; default: c = 2'd1;
                  endcase
      MODE_ALT_B: case (rank)
                    2'd0: c = 2'd2; 2'd1: c = 2'd0; 2'd2: c = 2'd1; default: c = 2'd3;
                  endcase
      MODE_ROTATE: c = p + rank;
      default:     c = rank;
    endcase
    return c;
  endfunction

  always_comb begin
    grantValid = 1'b0;
    grantIdx   = '0;
    // Walk from the lowest rank up, so the highest-ranked request is written last.
    for (int r = CH_NUM - 1; r >= 0; r--) begin
      logic [IDX_W-1:0] c;
      c = chanAt(ctrlIn.mode, ptrQ, IDX_W'(r));
      if (ctrlIn.allow && reqIn[c]) begin
        grantValid = 1'b1;
        grantIdx   = c;
      end
    end
    grantOneHot = grantValid ? (CH_NUM'(1) << grantIdx) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ptrQ <= '0;
    else if (ctrlIn.ptrReset)  ptrQ <= '0;
    else if (grantAck && grantValid && ctrlIn.mode == MODE_ROTATE)
      ptrQ <= grantIdx + 1'b1;
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        standbyClr,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  input  logic        regRdEn,
  output logic [15:0] regRdData,
  input  logic        addrErrEvt,
  input  logic        nmiEvt,
  input  logic [3:0]  reqIn,
  input  logic        grantAck,
  output logic        grantValid,
  output logic [1:0]  grantIdx,
  output logic [3:0]  grantOneHot
);
  arbCtrl_t ctrlBus;

  dma_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .standbyClr(standbyClr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .addrErrEvt(addrErrEvt), .nmiEvt(nmiEvt),
    .regRdData(regRdData), .ctrlOut(ctrlBus)
  );

  dma_arb_path u_path (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlBus), .reqIn(reqIn),
    .grantAck(grantAck), .grantValid(grantValid),
    .grantIdx(grantIdx), .grantOneHot(grantOneHot)
  );
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk (
  input logic        clk,
  input logic        rstN,
  input logic        standbyClr,
  input logic        regWrEn,
  input logic [15:0] regWrData,
  input logic        regRdEn,
  input logic [15:0] regRdData,
  input logic        addrErrEvt,
  input logic        nmiEvt,
  input logic [3:0]  reqIn,
  input logic        grantAck,
  input logic        grantValid,
  input logic [1:0]  grantIdx,
  input logic [3:0]  grantOneHot
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[15:10] == 6'd0 && regRdData[7:3] == 5'd0);

  p_linear_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && regRdData[9:8] == 2'b00 && reqIn[0]) |-> grantOneHot[0]);

  p_alt_b_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && regRdData[9:8] == 2'b10 && reqIn[2]) |-> grantOneHot[2]);

  p_blocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdData[0] || regRdData[2] || regRdData[1]) |-> !grantValid);

  p_event_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    (addrErrEvt && !standbyClr) |=> regRdData[2]);

  p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[1] && !standbyClr && !(regWrEn && !regWrData[1])) |=> regRdData[1]);

  p_standby_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    standbyClr |=> regRdData == 16'd0);

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOneHot) && (grantValid == (grantOneHot != 4'd0)));

  p_grant_on_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantOneHot[grantIdx] && (grantOneHot & ~reqIn) == 4'd0));
endmodule

bind dma_prio_arb dma_prio_arb_chk chk (.*);

// File: tb/dma_prio_arb_test.sv
module dma_prio_arb_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        standbyClr = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [15:0] regRdData;
  logic        addrErrEvt = 1'b0;
  logic        nmiEvt = 1'b0;
  logic [3:0]  reqIn = '0;
  logic        grantAck = 1'b0;
  logic        grantValid;
  logic [1:0]  grantIdx;
  logic [3:0]  grantOneHot;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          isGrant;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sbq[$];

  dma_prio_arb uut (.*);

  always #5 clk = ~clk;

  // Monitor: pops expectations between edges and compares.
  initial forever begin
    @(negedge clk); #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sbq.pop_front();
      act = it.isGrant ? {9'd0, grantValid, grantIdx, grantOneHot} : regRdData;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  // Expected grant from the orderings in R3..R6.
  function automatic logic [15:0] expGrant(logic [3:0] req, logic [1:0] mode,
                                           logic [1:0] ptr, bit allow);
    logic [1:0] ord [4];
    case (mode)
      2'b00: ord = '{2'd0, 2'd1, 2'd2, 2'd3};
      2'b01: ord = '{2'd0, 2'd2, 2'd3, 2'd1};
      2'b10: ord = '{2'd2, 2'd0, 2'd1, 2'd3};
      default: ord = '{ptr, ptr + 2'd1, ptr + 2'd2, ptr + 2'd3};
    endcase
    if (allow)
      for (int k = 0; k < 4; k++)
        if (req[ord[k]]) return {9'd0, 1'b1, ord[k], 4'(1 << ord[k])};
    return 16'd0;
  endfunction

  task automatic tick();
    @(posedge clk); #2;
    regWrEn = 0; regRdEn = 0; addrErrEvt = 0; nmiEvt = 0;
    grantAck = 0; standbyClr = 0;
  endtask

  task automatic expect_item(bit g, logic [15:0] e, string r);
    item_t it;
    it.isGrant = g; it.exp = e; it.req = r;
    sbq.push_back(it);
  endtask

  task automatic wr(logic [15:0] d);
    regWrEn = 1; regWrData = d; tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] ptr;
    #3; reqIn = 4'hF;
    expect_item(0, 16'h0000, "R1 reset register");
    expect_item(1, 16'h0000, "R1 no grant after reset");
    #20; rstN = 1; tick();

    wr(16'hFFFF);
    expect_item(0, 16'h0301, "R2 reserved bits read zero, R8 write-1 to flags ignored");
    tick();

    for (int m = 0; m < 3; m++) begin
      wr({6'd0, 2'(m), 8'h01});
      for (int p = 1; p < 16; p++) begin
        reqIn = 4'(p);
        expect_item(1, expGrant(4'(p), 2'(m), 2'd0, 1),
                    m == 0 ? "R3 linear order" : (m == 1 ? "R4 order 0,2,3,1" : "R5 order 2,0,1,3"));
        tick();
      end
    end

    // R6 round-robin
    wr(16'h0301);
    ptr = 0;
    reqIn = 4'hF;
    for (int s = 0; s < 6; s++) begin
      expect_item(1, expGrant(4'hF, 2'b11, ptr, 1), "R6 round-robin rotation");
      grantAck = 1; tick();
      ptr = ptr + 2'd1;
    end
    reqIn = 4'b1010;
    for (int s = 0; s < 4; s++) begin
      logic [15:0] g;
      g = expGrant(4'b1010, 2'b11, ptr, 1);
      expect_item(1, g, "R6 round-robin sparse requests");
      grantAck = 1; tick();
      ptr = g[5:4] + 2'd1;
    end
    reqIn = 4'hF;
    expect_item(1, expGrant(4'hF, 2'b11, ptr, 1), "R6 no advance without ack");
    tick();
    expect_item(1, expGrant(4'hF, 2'b11, ptr, 1), "R6 no advance without ack");
    tick();

    // R7 enable low
    wr(16'h0000);
    expect_item(1, 16'h0000, "R7 no grant when disabled");
    tick();
    wr(16'h0001);
    expect_item(1, expGrant(4'hF, 2'b00, 0, 1), "R7 grant when enabled");
    tick();

    // R8/R9 address error
    addrErrEvt = 1; tick();
    expect_item(0, 16'h0005, "R8 address-error event sets flag");
    expect_item(1, 16'h0000, "R7 no grant with address-error flag");
    tick();
    wr(16'h0001);
    expect_item(0, 16'h0005, "R8 write 0 without read leaves flag");
    regRdEn = 1; tick();
    wr(16'h0001);
    expect_item(0, 16'h0001, "R9 read then write 0 clears flag");
    expect_item(1, expGrant(4'hF, 2'b00, 0, 1), "R7 grant resumes after clear");
    tick();

    // R9 NMI: event beats clear
    nmiEvt = 1; tick();
    expect_item(0, 16'h0003, "R8 NMI event sets flag");
    regRdEn = 1; tick();
    regWrEn = 1; regWrData = 16'h0001; nmiEvt = 1; tick();
    expect_item(0, 16'h0003, "R9 event wins over clearing write");
    tick();
    wr(16'h0003);
    expect_item(0, 16'h0003, "R8 write 1 leaves NMI flag");
    tick();
    wr(16'h0001);
    expect_item(0, 16'h0001, "R9 armed NMI flag cleared by write 0");
    tick();

    // R10 standby
    wr(16'h0301);
    grantAck = 1; tick();
    grantAck = 1; tick();
    addrErrEvt = 1; tick();
    standbyClr = 1; tick();
    expect_item(0, 16'h0000, "R10 standby clears register");
    tick();
    wr(16'h0301);
    expect_item(1, expGrant(4'hF, 2'b11, 0, 1), "R10 round-robin restarts at channel 0");
    tick();
    tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule